// File: doc/BRIEF.md
# Reconfigurable Array Processing Element

This block is one processing element of a row-pipelined data-path array. It holds one arithmetic functional unit and one transfer unit. It has a configuration word that is loaded serially, and that word includes a 64-bit immediate constant. Two operand inputs feed the functional unit. A third input feeds the transfer unit. Each unit drives its own registered output, and each output has a valid flag. The element has no branching and no memory access. Every clock that carries data produces one result one cycle later.

Before streaming starts, the configuration word is shifted in one bit per clock. The word selects the arithmetic operation and the usage mode of the two units. It also selects whether the immediate replaces either operand. In one mode the functional unit acts as a second transfer path, so the element forwards two values in that mode. Arithmetic is 64-bit integer add, subtract and multiply. The results wrap modulo 2^64.

Top module: `rdp_pe`

## Requirements
- R1: While rst_n is low, both outputs are zero and both valid flags are low. The configuration word resets to all zeros, which means operation add, mode 0 and no immediate.
- R2: While cfg_en is high, each clock shifts cfg_bit into a 70-bit configuration word, least significant bit first. After 70 clocks the first bit sits at bit 0. The field layout is: bits 1:0 operation, bits 3:2 mode, bits 5:4 immediate select, bits 69:6 immediate value.
- R3: While cfg_en is high, the data inputs are ignored. In the cycle after each such clock, both valid flags are low and both outputs keep their previous values.
- R4: Operation code 0 adds, code 1 computes A minus B, code 2 multiplies and keeps the low 64 bits, and code 3 adds. All results wrap modulo 2^64.
- R5: When the transfer unit is in use, tu_out equals in_t from the previous clock.
- R6: An unused unit drives zero on its output with its valid flag low.
- R7: Mode encoding: 0 uses both units; 1 uses the functional unit only; 2 uses the transfer unit only; 3 makes the functional unit forward operand A unchanged while the transfer unit also forwards.
- R8: Immediate select bit 0 replaces operand A with the immediate, and bit 1 replaces operand B. This also applies to the value forwarded in mode 3.
- R9: The valid flag of a used unit equals in_valid from the previous clock, when cfg_en was low in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, least significant bit first |
| in_valid | input | 1 | Marks the data inputs as valid |
| in_a | input | 64 | Functional unit operand A |
| in_b | input | 64 | Functional unit operand B |
| in_t | input | 64 | Transfer unit input |
| fu_out | output | 64 | Registered functional unit result |
| fu_vld | output | 1 | Functional unit output valid |
| tu_out | output | 64 | Registered transfer unit output |
| tu_vld | output | 1 | Transfer unit output valid |

## Verification
The properties assume the following about the inputs:
- cfg_en and in_valid are clean 0/1 levels that change only between clock edges.
- Data inputs do not need to be stable while cfg_en is high, since the element ignores them then.
- A property that compares an output with the previous cycle's input or operand expects the configuration to have been static over that cycle.

The stimulus keeps within these assumptions in two ways. Every input is driven on the falling edge. A complete configuration word is always shifted in before any data is applied under it, so the mode and operand selection never change in a cycle that carries data.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int HDR_W = 6;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_ADDX = 2'd3
  } pe_op_e;

  typedef enum logic [1:0] {
    MD_BOTH = 2'd0,
    MD_FU   = 2'd1,
    MD_TU   = 2'd2,
    MD_DUAL = 2'd3
  } pe_mode_e;
endpackage

// File: rtl/pe_cfg_chain.sv
module pe_cfg_chain #(
  parameter int W = 70
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] word_q
);
  // New bits enter at the top and move down, so the first bit ends at bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {shift_in, word_q[W-1:1]};
  end
endmodule

// File: rtl/pe_fu.sv
module pe_fu
  import pe_pkg::*;
#(
  parameter int DW = 64
) (
  input  pe_op_e        op,
  input  logic          xfer,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  function automatic logic [DW-1:0] fu_calc(input pe_op_e o,
                                            input logic [DW-1:0] x,
                                            input logic [DW-1:0] z);
    case (o)
      OP_SUB:  return x - z;
      OP_MUL:  return x * z;
      default: return x + z;
    endcase
  endfunction

  assign y = xfer ? a : fu_calc(op, a, b);
endmodule

// File: rtl/pe_out_reg.sv
module pe_out_reg #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          used,
  input  logic          vld_in,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          v
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
      v <= 1'b0;
    end else if (hold) begin
      v <= 1'b0;
    end else begin
      v <= used & vld_in;
      q <= used ? d : '0;
    end
  end
endmodule

// File: rtl/rdp_pe.sv
module rdp_pe
  import pe_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_bit,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_t,
  output logic [DW-1:0] fu_out,
  output logic          fu_vld,
  output logic [DW-1:0] tu_out,
  output logic          tu_vld
);
  localparam int CW = HDR_W + DW;

  logic [CW-1:0] cfg_word;
  pe_op_e        op;
  pe_mode_e      mode;
  logic [1:0]    imm_sel;
  logic [DW-1:0] imm;
  logic [DW-1:0] op_a, op_b, fu_y;
  logic          fu_used, tu_used, fu_xfer;

  pe_cfg_chain #(.W(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .shift_in(cfg_bit),
    .word_q(cfg_word)
  );

  assign op      = pe_op_e'(cfg_word[1:0]);
  assign mode    = pe_mode_e'(cfg_word[3:2]);
  assign imm_sel = cfg_word[5:4];
  assign imm     = cfg_word[CW-1:HDR_W];

  // Named decode events used by the checker.
  assign fu_used = (mode != MD_TU);
  assign tu_used = (mode != MD_FU);
  assign fu_xfer = (mode == MD_DUAL);

  assign op_a = imm_sel[0] ? imm : in_a;
  assign op_b = imm_sel[1] ? imm : in_b;

  pe_fu #(.DW(DW)) u_fu (
    .op(op), .xfer(fu_xfer), .a(op_a), .b(op_b), .y(fu_y)
  );

  pe_out_reg #(.DW(DW)) u_fu_reg (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .used(fu_used),
    .vld_in(in_valid), .d(fu_y), .q(fu_out), .v(fu_vld)
  );

  pe_out_reg #(.DW(DW)) u_tu_reg (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .used(tu_used),
    .vld_in(in_valid), .d(in_t), .q(tu_out), .v(tu_vld)
  );
endmodule

// File: rtl/pe_chk.sv
module pe_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          in_valid,
  input logic [DW-1:0] in_t,
  input logic [DW-1:0] op_a,
  input logic          fu_used,
  input logic          tu_used,
  input logic          fu_xfer,
  input logic [DW-1:0] fu_out,
  input logic          fu_vld,
  input logic [DW-1:0] tu_out,
  input logic          tu_vld
);
  a_r3_cfg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (!fu_vld && !tu_vld && $stable(fu_out) && $stable(tu_out)));

  a_r5_tu_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && tu_used) |=> (tu_out == $past(in_t)));

  a_r6_fu_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !fu_used) |=> (!fu_vld && fu_out == '0));

  a_r6_tu_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !tu_used) |=> (!tu_vld && tu_out == '0));

  a_r7_fu_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && fu_xfer) |=> (fu_out == $past(op_a)));

  a_r9_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !in_valid) |=> (!fu_vld && !tu_vld));
endmodule

bind rdp_pe pe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .in_valid(in_valid),
  .in_t(in_t), .op_a(op_a), .fu_used(fu_used), .tu_used(tu_used),
  .fu_xfer(fu_xfer), .fu_out(fu_out), .fu_vld(fu_vld),
  .tu_out(tu_out), .tu_vld(tu_vld)
);

// File: tb/rdp_pe_tb_top.sv
`timescale 1ns/1ps
module rdp_pe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_bit = 1'b0, in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0, in_t = '0;
  logic [63:0] fu_out, tu_out;
  logic        fu_vld, tu_vld;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rdp_pe dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_t(in_t),
    .fu_out(fu_out), .fu_vld(fu_vld), .tu_out(tu_out), .tu_vld(tu_vld)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  mode;
    logic [1:0]  sel;
    logic [63:0] imm, a, b, t, ef;
    logic        efv;
    logic [63:0] et;
    logic        etv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 64'd0, 64'd5, 64'd7, 64'd9, 64'd12, 1'b1, 64'd9, 1'b1},          // R4 add, R7 both
    '{2'd1, 2'd0, 2'd0, 64'd0, 64'd3, 64'd10, 64'd1, 64'hFFFF_FFFF_FFFF_FFF9, 1'b1, 64'd1, 1'b1}, // R4 sub wrap
    '{2'd2, 2'd1, 2'd0, 64'd0, 64'h1_0000_0000, 64'h1_0000_0003, 64'd55, 64'h3_0000_0000, 1'b1, 64'd0, 1'b0}, // R4 mul low, R6 tu idle
    '{2'd0, 2'd2, 2'd0, 64'd0, 64'd8, 64'd8, 64'd77, 64'd0, 1'b0, 64'd77, 1'b1},        // R6 fu idle, R5
    '{2'd1, 2'd3, 2'd0, 64'd0, 64'h1234, 64'd99, 64'd66, 64'h1234, 1'b1, 64'd66, 1'b1}, // R7 dual
    '{2'd0, 2'd0, 2'd1, 64'd100, 64'd1, 64'd2, 64'd3, 64'd102, 1'b1, 64'd3, 1'b1},      // R8 imm A
    '{2'd1, 2'd1, 2'd2, 64'd100, 64'd250, 64'd7, 64'd3, 64'd150, 1'b1, 64'd0, 1'b0},    // R8 imm B
    '{2'd2, 2'd0, 2'd3, 64'd6, 64'd1, 64'd1, 64'd4, 64'd36, 1'b1, 64'd4, 1'b1},         // R8 both imm
    '{2'd2, 2'd3, 2'd1, 64'hABC, 64'd5, 64'd5, 64'd6, 64'hABC, 1'b1, 64'd6, 1'b1},      // R8 in dual
    '{2'd0, 2'd1, 2'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 64'd0, 1'b1, 64'd0, 1'b0}, // R4 add wrap
    '{2'd3, 2'd0, 2'd0, 64'd0, 64'd4, 64'd5, 64'd2, 64'd9, 1'b1, 64'd2, 1'b1},          // R4 code 3
    '{2'd2, 2'd0, 2'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 1'b1, 64'd0, 1'b1}, // R4 mul
    '{2'd0, 2'd3, 2'd1, 64'h8000_0000_0000_0001, 64'd0, 64'd0, 64'd5, 64'h8000_0000_0000_0001, 1'b1, 64'd5, 1'b1} // R2 full word
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: shift 70 bits, bit 0 first; layout op[1:0] mode[3:2] sel[5:4] imm[69:6].
  task automatic load_cfg(input logic [1:0] op, input logic [1:0] mode,
                          input logic [1:0] sel, input logic [63:0] imm);
    logic [69:0] w;
    w = {imm, sel, mode, op};
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [63:0] t);
    in_a = a; in_b = b; in_t = t; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fu_out", fu_out, 64'd0);
    check("R1 fu_vld", {63'd0, fu_vld}, 64'd0);
    check("R1 tu_out", tu_out, 64'd0);
    check("R1 tu_vld", {63'd0, tu_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 default configuration: add, both units, no immediate
    apply(64'd2, 64'd3, 64'd4);
    check("R1 default add", fu_out, 64'd5);
    check("R1 default tu", tu_out, 64'd4);

    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i].op, VECS[i].mode, VECS[i].sel, VECS[i].imm);
      apply(VECS[i].a, VECS[i].b, VECS[i].t);
      check("R4/R7/R8 fu_out", fu_out, VECS[i].ef);
      check("R6/R9 fu_vld", {63'd0, fu_vld}, {63'd0, VECS[i].efv});
      check("R5 tu_out", tu_out, VECS[i].et);
      check("R6/R9 tu_vld", {63'd0, tu_vld}, {63'd0, VECS[i].etv});
    end

    // R9: in_valid low gives low valid flags
    load_cfg(2'd0, 2'd0, 2'd0, 64'd0);
    in_a = 64'd10; in_b = 64'd20; in_t = 64'd30; in_valid = 1'b0;
    @(negedge clk);
    check("R9 fu_vld idle", {63'd0, fu_vld}, 64'd0);
    check("R9 tu_vld idle", {63'd0, tu_vld}, 64'd0);
    check("R4 add no valid", fu_out, 64'd30);

    // R3: data during cfg_en is ignored, outputs held
    apply(64'd40, 64'd2, 64'd8);
    held = fu_out;
    check("R3 setup", held, 64'd42);
    cfg_en = 1'b1; cfg_bit = 1'b0; in_valid = 1'b1;
    in_a = 64'd500; in_b = 64'd500; in_t = 64'd500;
    @(negedge clk);
    check("R3 fu_vld low", {63'd0, fu_vld}, 64'd0);
    check("R3 tu_vld low", {63'd0, tu_vld}, 64'd0);
    check("R3 fu_out held", fu_out, held);
    check("R3 tu_out held", tu_out, 64'd8);
    cfg_en = 1'b0; in_valid = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule